// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block decides which of five interrupt sources a processor core vectors to, and it keeps the nesting state of the services in progress. Sources are numbered 0 to 4: external 0, timer 0, external 1, timer 1 and serial. Each source has a pending request, an enable bit and a priority bit. The core gives a global enable and a strobe that marks an instruction boundary.

Arbitration runs only on a boundary strobe. When a source is granted, the block pulses a take strobe and presents the vector address and the source index. In the same cycle it issues the acknowledge strobe that clears the source's request and a wake strobe that clears the core's idle flag. It then holds the two-cycle vector transfer. The core does the program-counter push and saves the context. The core signals a return from interrupt, and the block then pops one nesting level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: No interrupt is taken unless `boundary_i` and `gen_i` are both high at the deciding clock edge; `take_o` is a registered one-cycle pulse in the cycle after that edge.
- R2: With no enabled pending source of priority 1, the winner is the enabled pending source with the lowest index (source 0 first, source 4 last). `src_o` shows the winner's index and `vec_o` shows 0x03 + 8 × index.
- R3: Any enabled pending source whose `prio_i` bit is 1 beats every low-priority winner. Among such sources, the lowest index wins.
- R4: While `act_hi_o` is 1, no interrupt is taken.
- R5: While `act_lo_o` is 1 and `act_hi_o` is 0, only a priority-1 request is taken. A priority-0 request stays untaken.
- R6: In the take cycle `clr_o` is one-hot on the winner for sources 1, 3 and 4, which auto-clear. For sources 0 and 2 it stays zero. It is zero in every other cycle.
- R7: Taking a priority-1 source sets `act_hi_o`. Taking a priority-0 source sets `act_lo_o`.
- R8: A `reti_i` pulse clears `act_hi_o` if it is set. Otherwise the pulse clears `act_lo_o`.
- R9: `idle_clr_o` pulses in exactly the take cycle. No power-down clear output exists.
- R10: `busy_o` is high for the take cycle and the cycle after it. A boundary strobe seen while `busy_o` is high is ignored.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 5 | Pending request per source, index = polling position |
| en_i | input | 5 | Per-source enable |
| prio_i | input | 5 | Per-source priority (1 = high) |
| gen_i | input | 1 | Global interrupt enable |
| boundary_i | input | 1 | Instruction boundary strobe |
| reti_i | input | 1 | Return-from-interrupt pulse |
| take_o | output | 1 | Vector-taken pulse |
| vec_o | output | 8 | Vector address |
| src_o | output | 3 | Granted source index |
| clr_o | output | 5 | Request-clear strobes |
| idle_clr_o | output | 1 | Clear idle flag strobe |
| busy_o | output | 1 | Vector transfer in progress |
| act_hi_o | output | 1 | High-priority service active |
| act_lo_o | output | 1 | Low-priority service active |

## Verification
The bench starts from an idle nesting state. It sweeps all 1024 combinations of request and priority vectors with every source enabled. This separates the low-priority polling order from the high-priority override and shows which sources clear. A second sweep crosses every enable mask with every request vector at low priority, which shows that masking removes a source from the poll. Directed sequences cover the nesting rules, the global-enable and boundary gating, a boundary strobe during the transfer, and the order in which returns pop the levels.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned N_SRC = 5;
  localparam int unsigned SRC_W = $clog2(N_SRC);
  localparam int unsigned VEC_W = 8;
  localparam int unsigned VEC_BASE = 3;
  localparam int unsigned VEC_STEP = 8;

  function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] idx);
    return VEC_W'(VEC_BASE + VEC_STEP * int'(idx));
  endfunction
endpackage

// File: rtl/irq_arb.sv
module irq_arb
  import irq_prio_pkg::*;
(
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] prio_i,
  output logic             any_o,
  output logic             hi_o,
  output logic [SRC_W-1:0] idx_o
);
  logic             lo_any, hi_any;
  logic [SRC_W-1:0] lo_idx, hi_idx;

  // scan from the top so the lowest index is written last and wins
  always_comb begin
    lo_any = 1'b0;
    hi_any = 1'b0;
    lo_idx = '0;
    hi_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        lo_any = 1'b1;
        lo_idx = SRC_W'(i);
        if (prio_i[i]) begin
          hi_any = 1'b1;
          hi_idx = SRC_W'(i);
        end
      end
    end
  end

  assign any_o = lo_any;
  assign hi_o  = hi_any;
  assign idx_o = hi_any ? hi_idx : lo_idx;
endmodule

// File: rtl/irq_nest.sv
module irq_nest (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic take_hi_i,
  input  logic reti_i,
  output logic act_hi_o,
  output logic act_lo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_hi_o <= 1'b0;
      act_lo_o <= 1'b0;
    end else begin
      if (reti_i) begin
        if (act_hi_o) act_hi_o <= 1'b0;
        else          act_lo_o <= 1'b0;
      end
      if (take_i) begin
        if (take_hi_i) act_hi_o <= 1'b1;
        else           act_lo_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_xfer.sv
module irq_xfer #(
  parameter int unsigned XFER_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(XFER_CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CNT_W'(XFER_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter logic [N_SRC-1:0] CLR_MASK = 5'b11010,
  parameter int unsigned      XFER_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] prio_i,
  input  logic             gen_i,
  input  logic             boundary_i,
  input  logic             reti_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [SRC_W-1:0] src_o,
  output logic [N_SRC-1:0] clr_o,
  output logic             idle_clr_o,
  output logic             busy_o,
  output logic             act_hi_o,
  output logic             act_lo_o
);
  logic             any_w, hi_w, grant;
  logic [SRC_W-1:0] idx_w;
  logic [N_SRC-1:0] onehot_w;

  irq_arb u_arb (
    .pend_i (req_i & en_i),
    .prio_i (prio_i),
    .any_o  (any_w),
    .hi_o   (hi_w),
    .idx_o  (idx_w)
  );

  // level gate: nothing over high, only high over low
  assign grant = boundary_i && gen_i && !busy_o && any_w
              && !act_hi_o && (!act_lo_o || hi_w);

  for (genvar g = 0; g < N_SRC; g++) begin : g_oh
    assign onehot_w[g] = (idx_w == SRC_W'(g)) && CLR_MASK[g];
  end

  irq_nest u_nest (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (grant),
    .take_hi_i (hi_w),
    .reti_i    (reti_i),
    .act_hi_o  (act_hi_o),
    .act_lo_o  (act_lo_o)
  );

  irq_xfer #(.XFER_CYC(XFER_CYC)) u_xfer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (grant),
    .busy_o  (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o     <= 1'b0;
      vec_o      <= '0;
      src_o      <= '0;
      clr_o      <= '0;
      idle_clr_o <= 1'b0;
    end else begin
      take_o     <= grant;
      idle_clr_o <= grant;
      clr_o      <= grant ? onehot_w : '0;
      if (grant) begin
        vec_o <= vec_of(idx_w);
        src_o <= idx_w;
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gen_i,
  input logic             boundary_i,
  input logic             reti_i,
  input logic             take_o,
  input logic [N_SRC-1:0] clr_o,
  input logic             busy_o,
  input logic             act_hi_o,
  input logic             act_lo_o
);
  AST_TAKE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(boundary_i && gen_i)); // R1
  AST_HI_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(act_hi_o) && $past(act_hi_o, 2)) |-> !take_o); // R4
  AST_LO_ONLY_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && $past(act_lo_o, 2) && !$past(reti_i, 2)) |-> act_hi_o); // R5
  AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o)); // R6
  AST_CLR_IN_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_o) |-> take_o); // R6
  AST_TAKE_SETS_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (act_hi_o || act_lo_o)); // R7
  AST_TAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (!take_o && busy_o)); // R10
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gen_i      (gen_i),
  .boundary_i (boundary_i),
  .reti_i     (reti_i),
  .take_o     (take_o),
  .clr_o      (clr_o),
  .busy_o     (busy_o),
  .act_hi_o   (act_hi_o),
  .act_lo_o   (act_lo_o)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  localparam time CLK_PER = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] req_i = '0, en_i = '0, prio_i = '0;
  logic       gen_i = 1'b0, boundary_i = 1'b0, reti_i = 1'b0;
  logic       take_o, idle_clr_o, busy_o, act_hi_o, act_lo_o;
  logic [7:0] vec_o;
  logic [2:0] src_o;
  logic [4:0] clr_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PER/2) clk_i = ~clk_i;

  irq_prio_ctrl dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  // reference: returns winner index or -1, and whether it is high priority
  function automatic int ref_pick(input logic [4:0] pend, input logic [4:0] pr, output bit hi);
    hi = 0;
    for (int i = 0; i < 5; i++) if (pend[i] && pr[i]) begin hi = 1; return i; end
    for (int i = 0; i < 5; i++) if (pend[i]) return i;
    return -1;
  endfunction

  // apply one boundary strobe and check the take cycle
  task automatic strobe_chk(input bit exp_take, input int exp_idx, input string tag);
    logic [4:0] exp_clr;
    boundary_i = 1'b1;
    step();
    boundary_i = 1'b0;
    chk(take_o == exp_take, {tag, " take"}, take_o, exp_take);
    chk(idle_clr_o == exp_take, "R9 idle_clr", idle_clr_o, exp_take);
    if (exp_take) begin
      exp_clr = ((exp_idx == 1) || (exp_idx == 3) || (exp_idx == 4)) ? 5'(1 << exp_idx) : 5'b0;
      chk(int'(src_o) == exp_idx, {tag, " src"}, src_o, exp_idx);
      chk(int'(vec_o) == 3 + 8 * exp_idx, {tag, " vec"}, vec_o, 3 + 8 * exp_idx);
      chk(clr_o == exp_clr, "R6 clr", clr_o, exp_clr);
      chk(busy_o == 1'b1, "R10 busy0", busy_o, 1);
      step();
      chk(busy_o == 1'b1 && take_o == 1'b0, "R10 busy1", {busy_o, take_o}, 2);
      step();
      chk(busy_o == 1'b0, "R10 busy2", busy_o, 0);
    end else begin
      chk(clr_o == 5'b0, "R6 clr idle", clr_o, 0);
    end
  endtask

  task automatic reti();
    reti_i = 1'b1;
    step();
    reti_i = 1'b0;
  endtask

  initial begin
    #(CLK_PER * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit hi;
    int w;
    step();
    step();
    chk({take_o, vec_o, src_o, clr_o, idle_clr_o, busy_o, act_hi_o, act_lo_o} == '0,
        "R11 reset", take_o, 0);
    rst_ni = 1'b1;
    step();

    // R2/R3/R6/R7 sweep: all enabled, all request x priority
    gen_i = 1'b1;
    en_i  = 5'h1f;
    for (int r = 0; r < 32; r++) begin
      for (int p = 0; p < 32; p++) begin
        req_i = 5'(r); prio_i = 5'(p);
        w = ref_pick(5'(r), 5'(p), hi);
        strobe_chk(w >= 0, w, hi ? "R3" : "R2");
        if (w >= 0) begin
          chk(act_hi_o == hi && act_lo_o == !hi, "R7 act", {act_hi_o, act_lo_o}, {hi, !hi});
          reti();
          chk(!act_hi_o && !act_lo_o, "R8 pop", {act_hi_o, act_lo_o}, 0);
        end
      end
    end

    // R2 enable sweep at low priority
    prio_i = '0;
    for (int e = 0; e < 32; e++) begin
      for (int r = 0; r < 32; r++) begin
        en_i = 5'(e); req_i = 5'(r);
        w = ref_pick(5'(e & r), 5'b0, hi);
        strobe_chk(w >= 0, w, "R2 en");
        if (w >= 0) reti();
      end
    end
    en_i = 5'h1f;

    // R1 gating
    req_i = 5'b00100; gen_i = 1'b0;
    strobe_chk(1'b0, 0, "R1 gen");
    gen_i = 1'b1;
    step(); step();
    chk(take_o == 1'b0, "R1 noboundary", take_o, 0);

    // R5: low active blocks low, admits high
    prio_i = 5'b00000; req_i = 5'b00001;
    strobe_chk(1'b1, 0, "R5 lo");
    req_i = 5'b00010;
    strobe_chk(1'b0, 0, "R5 lo blocked");
    chk(act_lo_o && !act_hi_o, "R5 state", {act_hi_o, act_lo_o}, 1);
    prio_i = 5'b10000; req_i = 5'b10010;
    strobe_chk(1'b1, 4, "R5 hi preempt");
    chk(act_hi_o && act_lo_o, "R7 both", {act_hi_o, act_lo_o}, 3);
    // R4: high active blocks everything
    prio_i = 5'b11111; req_i = 5'b00001;
    strobe_chk(1'b0, 0, "R4 blocked");
    // R8: pop order
    reti();
    chk(!act_hi_o && act_lo_o, "R8 pop hi", {act_hi_o, act_lo_o}, 1);
    reti();
    chk(!act_hi_o && !act_lo_o, "R8 pop lo", {act_hi_o, act_lo_o}, 0);

    // R10: boundary during transfer ignored
    prio_i = '0; req_i = 5'b01000;
    boundary_i = 1'b1;
    step();
    chk(take_o == 1'b1 && int'(src_o) == 3, "R10 first", src_o, 3);
    step();
    chk(take_o == 1'b0, "R10 ignored a", take_o, 0);
    prio_i = 5'b11111;
    step();
    boundary_i = 1'b0;
    chk(take_o == 1'b0 && act_hi_o == 1'b0, "R10 ignored b", {take_o, act_hi_o}, 0);
    reti();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule